// File: doc/BRIEF.md
# Query Command Decoder and Bit Extractor

This block sits between the network side of a memory node and a 256-bit-wide connection memory. A query arrives as eleven segments, one for each cluster in ascending cluster order. Each segment carries a one-bit known flag and an 8-bit value. For a known cluster the value is a neuron index. For a missing cluster it is the identifier of the processing element that should receive the results. Once the whole query is stored, the block reads one memory word for each known cluster. The address comes from a per-cluster base table plus the neuron index.

Each word read is then sliced once for every missing cluster. A barrel shifter moves the missing cluster's highest connection bit to bit 255. The block then emits 32-bit flits: the top lane always, and one or two further lanes when that cluster's width enable asks for them. Every flit carries the destination processing element and the known cluster whose row supplied the bits. The sender never needs to know how connections are laid out in memory, because the three per-cluster tables hold that layout. The tables are loaded through a small write port.

Top module: `qx_extractor`

## Requirements
- R1: A segment is taken on a clock edge where seg_valid and seg_ready are both high. seg_known=1 marks a known cluster and seg_value is then its neuron index. seg_known=0 marks a missing cluster and seg_value is then its processing-element id. Segments fill clusters 0 to 10 in order. seg_ready is high only while a query is being collected, and never in a cycle that drives flit_valid or mem_rd.
- R2: For each known cluster, in ascending cluster order, mem_rd is high for exactly one cycle. During that cycle mem_addr = (base[c] + index) mod 256.
- R3: The word on mem_rdata in the cycle after mem_rd is the word that gets sliced.
- R4: The first flit for each missing cluster m is bits [255:224] of the word shifted left by 255 - top[m].
- R5: Width-enable bit 0 of cluster m adds the flit taken from bits [223:192], and bit 1 adds the flit from bits [191:160]. Flits for one cluster leave in lane order.
- R6: Flit order: for each known cluster k in ascending order, every missing cluster m in ascending order gets its flits from k's word.
- R7: flit_pe carries the processing-element id given for m, and flit_src carries k.
- R8: A query with no known cluster makes no read and no flit. A query with no missing cluster makes reads but no flit.
- R9: While flit_valid is high and flit_ready is low, the flit and its sideband fields hold steady.
- R10: A cfg_we pulse writes cfg_data into the table chosen by cfg_tbl, at entry cfg_cid. cfg_tbl=0 selects base, 1 selects top bit and 2 selects width enables (cfg_data[1:0]). The next query uses the new entry.
- R11: While rst_n is low, and for two cycles after it rises, seg_ready, mem_rd and flit_valid stay low. After that seg_ready goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_tbl | input | 2 | Table select: 0 base, 1 top bit, 2 width enables |
| cfg_cid | input | 4 | Cluster entry to write |
| cfg_data | input | 8 | Table write data |
| seg_valid | input | 1 | Segment offered |
| seg_ready | output | 1 | Segment accepted when high |
| seg_known | input | 1 | 1 known cluster, 0 missing cluster |
| seg_value | input | 8 | Neuron index or processing-element id |
| mem_addr | output | 8 | Memory word address |
| mem_rd | output | 1 | Memory read strobe |
| mem_rdata | input | 256 | Memory word, valid the cycle after mem_rd |
| flit_valid | output | 1 | Flit offered |
| flit_ready | input | 1 | Flit accepted when high |
| flit_data | output | 32 | Connection bits |
| flit_pe | output | 8 | Destination processing element |
| flit_src | output | 4 | Known cluster that supplied the word |

## Verification
The assertions assume three things about the inputs. The tables are written only between queries, while seg_ready is high. The memory presents its word in the cycle after mem_rd and keeps it steady until the next read. Every query has exactly eleven segments. The bench keeps to all three: it issues table writes only while the block is idle, answers each read one cycle later from a computed memory image, and always sends full eleven-segment queries. Flit acceptance is varied between always-ready, alternating, sparse and long-stall patterns so that backpressure reaches every lane.

// File: rtl/qx_pkg.sv
package qx_pkg;
  typedef enum logic [2:0] {
    ST_COLLECT = 3'd0,
    ST_SCAN_K  = 3'd1,
    ST_CAPT    = 3'd2,
    ST_SCAN_M  = 3'd3,
    ST_EMIT    = 3'd4
  } qx_state_e;

  localparam logic [1:0] TBL_BASE  = 2'd0;
  localparam logic [1:0] TBL_TOP   = 2'd1;
  localparam logic [1:0] TBL_WIDTH = 2'd2;
endpackage

// File: rtl/qx_cfg_tables.sv
module qx_cfg_tables #(
  parameter int NCLU  = 11,
  parameter int CIDW  = 4,
  parameter int IDXW  = 8,
  parameter int SHW   = 8,
  parameter int NFLIT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       tbl,
  input  logic [CIDW-1:0]  wcid,
  input  logic [IDXW-1:0]  wdata,
  input  logic [CIDW-1:0]  rk,
  input  logic [CIDW-1:0]  rm,
  output logic [IDXW-1:0]  base_o,
  output logic [SHW-1:0]   top_o,
  output logic [NFLIT-2:0] wen_o
);
  import qx_pkg::*;

  logic [IDXW-1:0]  base_q [NCLU];
  logic [SHW-1:0]   top_q  [NCLU];
  logic [NFLIT-2:0] wen_q  [NCLU];
  logic             in_rng;

  assign in_rng = (wcid < CIDW'(NCLU));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCLU; i++) begin
        base_q[i] <= '0;
        top_q[i]  <= '0;
        wen_q[i]  <= '0;
      end
    end else if (we && in_rng) begin
      if (tbl == TBL_BASE)  base_q[wcid] <= wdata;
      if (tbl == TBL_TOP)   top_q[wcid]  <= wdata[SHW-1:0];
      if (tbl == TBL_WIDTH) wen_q[wcid]  <= wdata[NFLIT-2:0];
    end
  end

  assign base_o = base_q[rk];
  assign top_o  = top_q[rm];
  assign wen_o  = wen_q[rm];

  // R10: a base write is visible on the following cycle
  p_tbl_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (we && in_rng && tbl == TBL_BASE) |=> (base_q[$past(wcid)] == $past(wdata)));
endmodule

// File: rtl/qx_cmd_store.sv
module qx_cmd_store #(
  parameter int NCLU = 11,
  parameter int CIDW = 4,
  parameter int IDXW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accept,
  input  logic                 in_valid,
  input  logic                 in_known,
  input  logic [IDXW-1:0]      in_value,
  output logic                 in_ready,
  output logic                 done,
  output logic [NCLU-1:0]      known_vec,
  output logic [NCLU*IDXW-1:0] val_flat
);
  localparam logic [CIDW-1:0] LASTC = CIDW'(NCLU - 1);

  logic [CIDW-1:0] pos_q, pos_d;
  logic            take;

  assign in_ready = accept;
  assign take     = accept && in_valid;
  assign done     = take && (pos_q == LASTC);

  always_comb begin
    pos_d = pos_q;
    if (take) pos_d = (pos_q == LASTC) ? '0 : pos_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q     <= '0;
      known_vec <= '0;
      val_flat  <= '0;
    end else begin
      pos_q <= pos_d;
      if (take) begin
        known_vec[pos_q]             <= in_known;
        val_flat[pos_q*IDXW +: IDXW] <= in_value;
      end
    end
  end

  // R1: the segment position never runs past the last cluster
  p_pos_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (pos_q <= LASTC));
endmodule

// File: rtl/qx_slicer.sv
module qx_slicer #(
  parameter int WORDW = 256,
  parameter int FLITW = 32,
  parameter int NFLIT = 3,
  parameter int SHW   = 8,
  parameter int FJW   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [WORDW-1:0] rdata,
  input  logic [SHW-1:0]   top,
  input  logic [FJW-1:0]   lane_sel,
  output logic [FLITW-1:0] flit
);
  logic [WORDW-1:0] word_q;
  logic [WORDW-1:0] shifted;
  logic [SHW-1:0]   shamt;
  logic [FLITW-1:0] lanes [NFLIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      word_q <= '0;
    else if (cap_en) word_q <= rdata;
  end

  assign shamt   = SHW'(WORDW - 1) - top;
  assign shifted = word_q << shamt;

  for (genvar g = 0; g < NFLIT; g++) begin : g_lane
    assign lanes[g] = shifted[WORDW-1-g*FLITW -: FLITW];
  end

  assign flit = (int'(lane_sel) < NFLIT) ? lanes[lane_sel] : '0;
endmodule

// File: rtl/qx_extractor.sv
module qx_extractor #(
  parameter int NCLU  = 11,
  parameter int CIDW  = 4,
  parameter int IDXW  = 8,
  parameter int WORDW = 256,
  parameter int FLITW = 32,
  parameter int NFLIT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_tbl,
  input  logic [CIDW-1:0]  cfg_cid,
  input  logic [IDXW-1:0]  cfg_data,
  input  logic             seg_valid,
  output logic             seg_ready,
  input  logic             seg_known,
  input  logic [IDXW-1:0]  seg_value,
  output logic [IDXW-1:0]  mem_addr,
  output logic             mem_rd,
  input  logic [WORDW-1:0] mem_rdata,
  output logic             flit_valid,
  input  logic             flit_ready,
  output logic [FLITW-1:0] flit_data,
  output logic [IDXW-1:0]  flit_pe,
  output logic [CIDW-1:0]  flit_src
);
  import qx_pkg::*;

  localparam int SHW = $clog2(WORDW);
  localparam int FJW = (NFLIT > 2) ? $clog2(NFLIT) : 1;
  localparam logic [CIDW-1:0] LASTC = CIDW'(NCLU - 1);

  // reset asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  qx_state_e          st_q, st_d;
  logic [CIDW-1:0]    kc_q, kc_d, mc_q, mc_d;
  logic [FJW-1:0]     fj_q, fj_d, nxt_j;
  logic               nxt_found, step_m, cap_en, cmd_done, accept;
  logic [NCLU-1:0]    known_vec;
  logic [NCLU*IDXW-1:0] val_flat;
  logic [IDXW-1:0]    base_k, val_k, val_m;
  logic [SHW-1:0]     top_m;
  logic [NFLIT-2:0]   wen_m;

  assign accept = (st_q == ST_COLLECT) && rst_i_n;

  qx_cfg_tables #(.NCLU(NCLU), .CIDW(CIDW), .IDXW(IDXW), .SHW(SHW), .NFLIT(NFLIT)) u_tables (
    .clk(clk), .rst_n(rst_i_n), .we(cfg_we), .tbl(cfg_tbl), .wcid(cfg_cid),
    .wdata(cfg_data), .rk(kc_q), .rm(mc_q), .base_o(base_k), .top_o(top_m), .wen_o(wen_m));

  qx_cmd_store #(.NCLU(NCLU), .CIDW(CIDW), .IDXW(IDXW)) u_store (
    .clk(clk), .rst_n(rst_i_n), .accept(accept), .in_valid(seg_valid),
    .in_known(seg_known), .in_value(seg_value), .in_ready(seg_ready),
    .done(cmd_done), .known_vec(known_vec), .val_flat(val_flat));

  qx_slicer #(.WORDW(WORDW), .FLITW(FLITW), .NFLIT(NFLIT), .SHW(SHW), .FJW(FJW)) u_slicer (
    .clk(clk), .rst_n(rst_i_n), .cap_en(cap_en), .rdata(mem_rdata),
    .top(top_m), .lane_sel(fj_q), .flit(flit_data));

  assign val_k = val_flat[kc_q*IDXW +: IDXW];
  assign val_m = val_flat[mc_q*IDXW +: IDXW];

  // next enabled lane above the current one
  always_comb begin
    nxt_found = 1'b0;
    nxt_j     = '0;
    for (int i = NFLIT - 1; i >= 1; i--) begin
      if ((FJW'(i) > fj_q) && wen_m[i-1]) begin
        nxt_found = 1'b1;
        nxt_j     = FJW'(i);
      end
    end
  end

  always_comb begin
    st_d   = st_q;
    kc_d   = kc_q;
    mc_d   = mc_q;
    fj_d   = fj_q;
    cap_en = 1'b0;
    step_m = 1'b0;
    unique case (st_q)
      ST_COLLECT: if (cmd_done) begin
        st_d = ST_SCAN_K;
        kc_d = '0;
      end
      ST_SCAN_K: begin
        if (known_vec[kc_q])    st_d = ST_CAPT;
        else if (kc_q == LASTC) st_d = ST_COLLECT;
        else                    kc_d = kc_q + 1'b1;
      end
      ST_CAPT: begin
        cap_en = 1'b1;
        mc_d   = '0;
        st_d   = ST_SCAN_M;
      end
      ST_SCAN_M: begin
        if (!known_vec[mc_q]) begin
          fj_d = '0;
          st_d = ST_EMIT;
        end else begin
          step_m = 1'b1;
        end
      end
      ST_EMIT: if (flit_ready) begin
        if (nxt_found) fj_d = nxt_j;
        else           step_m = 1'b1;
      end
      default: st_d = ST_COLLECT;
    endcase
    if (step_m) begin
      if (mc_q != LASTC) begin
        mc_d = mc_q + 1'b1;
        st_d = ST_SCAN_M;
      end else if (kc_q != LASTC) begin
        kc_d = kc_q + 1'b1;
        st_d = ST_SCAN_K;
      end else begin
        st_d = ST_COLLECT;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q <= ST_COLLECT;
      kc_q <= '0;
      mc_q <= '0;
      fj_q <= '0;
    end else begin
      st_q <= st_d;
      kc_q <= kc_d;
      mc_q <= mc_d;
      fj_q <= fj_d;
    end
  end

  assign mem_rd     = (st_q == ST_SCAN_K) && known_vec[kc_q];
  assign mem_addr   = base_k + val_k;
  assign flit_valid = (st_q == ST_EMIT);
  assign flit_pe    = val_m;
  assign flit_src   = kc_q;

  // R2: each read strobe lasts a single cycle
  p_rd_pulse_r2: assert property (@(posedge clk) disable iff (!rst_i_n)
    mem_rd |=> !mem_rd);

  // R9: a stalled flit keeps data and sideband
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (flit_valid && !flit_ready) |=>
      (flit_valid && $stable(flit_data) && $stable(flit_pe) && $stable(flit_src)));

  // R1: collecting never overlaps reads or flits
  p_idle_only_r1: assert property (@(posedge clk) disable iff (!rst_i_n)
    seg_ready |-> (!flit_valid && !mem_rd));

  // R5: an extra lane is only shown when its enable is set
  p_lane_en_r5: assert property (@(posedge clk) disable iff (!rst_i_n)
    (flit_valid && fj_q != '0) |-> wen_m[fj_q - 1'b1]);

  // R3: a read is always followed by a slice before the next read
  p_rd_then_flit_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    mem_rd |=> (!mem_rd && !seg_ready));
endmodule

// File: tb/qx_extractor_test.sv
`timescale 1ns/1ps
module qx_extractor_test;
  localparam int NCLU = 11;

  logic         clk, rst_n;
  logic         cfg_we;
  logic [1:0]   cfg_tbl;
  logic [3:0]   cfg_cid;
  logic [7:0]   cfg_data;
  logic         seg_valid, seg_ready, seg_known;
  logic [7:0]   seg_value;
  logic [7:0]   mem_addr;
  logic         mem_rd;
  logic [255:0] mem_rdata;
  logic         flit_valid, flit_ready;
  logic [31:0]  flit_data;
  logic [7:0]   flit_pe;
  logic [3:0]   flit_src;

  qx_extractor uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_tbl(cfg_tbl), .cfg_cid(cfg_cid),
    .cfg_data(cfg_data), .seg_valid(seg_valid), .seg_ready(seg_ready),
    .seg_known(seg_known), .seg_value(seg_value), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_rdata(mem_rdata), .flit_valid(flit_valid), .flit_ready(flit_ready),
    .flit_data(flit_data), .flit_pe(flit_pe), .flit_src(flit_src));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {known mask, value base, value step, ready mode}
  localparam logic [28:0] VEC [5] = '{
    {11'h008, 8'd4,   8'd15, 2'd0},
    {11'h421, 8'd9,   8'd7,  2'd1},
    {11'h2AA, 8'd200, 8'd11, 2'd2},
    {11'h7FE, 8'd1,   8'd23, 2'd1},
    {11'h001, 8'd250, 8'd3,  2'd2}
  };

  int checks = 0, fails = 0, cyc = 0, rmode = 0;
  logic [7:0] t_off [NCLU];
  logic [7:0] t_top [NCLU];
  logic [1:0] t_wen [NCLU];
  int nrd, nfl, e_nrd, e_nfl;
  logic [7:0]  r_addr [64];
  logic [31:0] r_data [512];
  logic [7:0]  r_pe   [512];
  logic [3:0]  r_src  [512];
  logic [7:0]  e_addr [64];
  logic [31:0] e_data [512];
  logic [7:0]  e_pe   [512];
  logic [3:0]  e_src  [512];
  int          e_lane [512];
  logic        stalled;
  logic [31:0] stall_data;

  function automatic logic [255:0] memf(input logic [7:0] a);
    logic [255:0] w;
    for (int i = 0; i < 32; i++) w[i*8 +: 8] = a + 8'(i * 37);
    return w;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // ready pattern, flit/read recording and memory model, away from the edge
  always @(negedge clk) begin
    cyc++;
    case (rmode)
      0: flit_ready = 1'b1;
      1: flit_ready = cyc[0];
      2: flit_ready = (cyc % 3 == 0);
      default: flit_ready = (cyc % 24 >= 20);
    endcase
    #0.5;
    if (rmode == 3 && stalled && flit_valid)
      chk(flit_data == stall_data, "R9", "stalled flit", flit_data, stall_data);
    stalled    = flit_valid && !flit_ready;
    stall_data = flit_data;
    if (flit_valid && flit_ready) begin
      if (nfl < 512) begin
        r_data[nfl] = flit_data;
        r_pe[nfl]   = flit_pe;
        r_src[nfl]  = flit_src;
      end
      nfl++;
    end
    if (mem_rd) begin
      if (nrd < 64) r_addr[nrd] = mem_addr;
      nrd++;
      mem_rdata = memf(mem_addr);
    end
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic cfgw(input logic [1:0] tbl, input int cid, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_tbl = tbl; cfg_cid = 4'(cid); cfg_data = d;
    if (tbl == 2'd0) t_off[cid] = d;
    if (tbl == 2'd1) t_top[cid] = d;
    if (tbl == 2'd2) t_wen[cid] = d[1:0];
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run(input logic [10:0] mask, input logic [7:0] base,
                     input logic [7:0] step, input int mode, input string tag);
    logic [7:0]   val [NCLU];
    logic [255:0] w, sh;
    int wt;
    for (int c = 0; c < NCLU; c++) val[c] = base + 8'(step * c);
    e_nrd = 0; e_nfl = 0;
    for (int k = 0; k < NCLU; k++) if (mask[k]) begin
      e_addr[e_nrd] = t_off[k] + val[k];
      w = memf(e_addr[e_nrd]);
      e_nrd++;
      for (int m = 0; m < NCLU; m++) if (!mask[m]) begin
        sh = w << (255 - int'(t_top[m]));
        for (int j = 0; j < 3; j++) if (j == 0 || t_wen[m][j-1]) begin
          e_data[e_nfl] = sh[255-32*j -: 32];
          e_pe[e_nfl] = val[m]; e_src[e_nfl] = 4'(k); e_lane[e_nfl] = j;
          e_nfl++;
        end
      end
    end
    rmode = mode; nrd = 0; nfl = 0; stalled = 1'b0;
    for (int c = 0; c < NCLU; c++) begin
      @(negedge clk);
      chk(seg_ready == 1'b1, "R1", {tag, " seg_ready while collecting"}, 64'(seg_ready), 1);
      seg_valid = 1'b1; seg_known = mask[c]; seg_value = val[c];
    end
    @(negedge clk);
    seg_valid = 1'b0;
    wt = 0;
    while (!seg_ready && wt < 20000) begin @(negedge clk); wt++; end
    repeat (3) @(negedge clk);
    chk(nrd == e_nrd, "R2 R8", {tag, " read count"}, 64'(nrd), 64'(e_nrd));
    for (int i = 0; i < e_nrd && i < nrd; i++)
      chk(r_addr[i] == e_addr[i], "R2", {tag, " read address"}, 64'(r_addr[i]), 64'(e_addr[i]));
    chk(nfl == e_nfl, "R6 R8", {tag, " flit count"}, 64'(nfl), 64'(e_nfl));
    for (int i = 0; i < e_nfl && i < nfl; i++) begin
      chk(r_data[i] == e_data[i], (e_lane[i] == 0) ? "R3 R4" : "R5",
          {tag, " flit data"}, 64'(r_data[i]), 64'(e_data[i]));
      chk({r_pe[i], r_src[i]} == {e_pe[i], e_src[i]}, "R7",
          {tag, " sideband pe/src"}, 64'({r_pe[i], r_src[i]}), 64'({e_pe[i], e_src[i]}));
    end
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_tbl = '0; cfg_cid = '0; cfg_data = '0;
    seg_valid = 1'b0; seg_known = 1'b0; seg_value = '0;
    mem_rdata = '0; flit_ready = 1'b1; nrd = 0; nfl = 0; stalled = 1'b0; stall_data = '0;
    repeat (3) @(negedge clk);
    chk({seg_ready, mem_rd, flit_valid} == 3'b000, "R11", "outputs in reset",
        64'({seg_ready, mem_rd, flit_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(seg_ready == 1'b0, "R11", "ready held after release", 64'(seg_ready), 0);
    repeat (3) @(negedge clk);
    chk(seg_ready == 1'b1, "R11", "ready after release", 64'(seg_ready), 1);

    for (int c = 0; c < NCLU; c++) begin
      cfgw(2'd0, c, (c == 3) ? 8'd79 : 8'(c * 29 + 13));
      cfgw(2'd1, c, (c == 0) ? 8'd255 : (c == 1) ? 8'd0 : 8'(c * 23 + 31));
      cfgw(2'd2, c, 8'(c % 4));
    end

    // R2: base 79 plus index 49 must address word 128
    run(11'h008, 8'd4, 8'd15, 0, "addr128");
    chk(r_addr[0] == 8'd128, "R2", "worked address", 64'(r_addr[0]), 128);

    for (int v = 0; v < 5; v++)
      run(VEC[v][28:18], VEC[v][17:10], VEC[v][9:2], int'(VEC[v][1:0]), $sformatf("vec%0d", v));

    run(11'h000, 8'd5, 8'd1, 0, "all-missing R8");
    run(11'h7FF, 8'd5, 8'd1, 0, "all-known R8");

    // R10: rewritten entries take effect on the next query
    cfgw(2'd0, 3, 8'd100);
    cfgw(2'd1, 5, 8'd200);
    cfgw(2'd2, 5, 8'd3);
    run(11'h008, 8'd4, 8'd15, 0, "rewrite R10");
    chk(r_addr[0] == 8'd149, "R10", "new base used", 64'(r_addr[0]), 149);

    // R9: long stalls on every lane
    run(11'h421, 8'd9, 8'd7, 3, "stall R9");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule